// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the processor-side entry step when the core takes an exception or an external interrupt. On a one-cycle take strobe it looks at the pending exception (a code plus a separate valid bit), the interrupt request, and the vector the interrupt controller offers. It also reads the current status word, program counter, stack register, vector base and delay-slot flag. From these it decides whether to vector, to ignore the event, or to escalate to a reset request.

When the block vectors, it saves the old status, PC and stack register into shadow registers. It forces the privileged, blocked and register-bank bits and picks the new PC from the exception code or from the interrupt path. It records the event code, rolls the saved PC back over a delay slot, and moves it forward for a trap instruction. All results are registered and appear on the cycle after the strobe. The pipeline, the register file and the interrupt controller sit outside the block and are seen only as ports.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception is pending (excValid=1), any interrupt request in the same take is not serviced: expevtOut receives excCode and intevtOut keeps its previous value.
- R2: When status bit 28 (block) is set and a pending exception has a code other than 0x1E0, resetReq pulses for one cycle after the take. done stays 0 and no saved register or PC output changes. A code of 0x1E0 is vectored normally.
- R3: When status bit 28 is set, an interrupt is ignored (no done, no sleepClr) unless the sleeping input is 1, in which case it is serviced.
- R4: On entry, done and sleepClr pulse on the cycle after the take. ssrOut takes the old status, spcOut the old PC and sgrOut the old stack register. srOut is the old status with bits 28 (block), 29 (bank) and 30 (privileged) set.
- R5: If inDelaySlot is 1 on an entry, spcOut is PC minus 2 and delayClr pulses together with done.
- R6: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), force status bits 7:4 to 0xF, and set pcOut to 0xA0000000.
- R7: Exception codes 0x040 and 0x060 set pcOut to VBR+0x400. Every other exception code sets pcOut to VBR+0x100.
- R8: Exception code 0x160 adds 2 to the saved PC; together with a delay slot the two adjustments cancel.
- R9: irqLevel always shows status bits 7:4. An accepted interrupt with a valid controller vector writes the vector to intevtOut and sets pcOut to VBR+0x600. With no valid vector there is no entry, though sleepClr still pulses.
- R10: An interrupt request is not accepted while inDelaySlot is 1.
- R11: Without a take strobe, done, resetReq, sleepClr and delayClr stay 0 and the registered outputs hold. All of them are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| take | input | 1 | One-cycle strobe: evaluate pending events now |
| excValid | input | 1 | An exception is pending |
| excCode | input | CODEW | Pending exception code |
| irqReq | input | 1 | External interrupt request |
| ctrlVecValid | input | 1 | Interrupt controller offers a vector above the mask |
| ctrlVec | input | VECW | Vector offered by the interrupt controller |
| irqLevel | output | MASKW | Current mask level sent to the controller |
| srIn | input | XLEN | Current status word |
| pcIn | input | XLEN | PC of the trapped instruction |
| r15In | input | XLEN | Current stack register |
| vbrIn | input | XLEN | Vector base |
| inDelaySlot | input | 1 | Instruction sits in a branch delay slot |
| sleeping | input | 1 | Core is in sleep |
| done | output | 1 | Entry performed (registered results valid) |
| resetReq | output | 1 | Blocked exception escalated to reset |
| sleepClr | output | 1 | Clear the core's sleep flag |
| delayClr | output | 1 | Clear the core's delay-slot flag |
| srOut | output | XLEN | New status word |
| pcOut | output | XLEN | New PC |
| spcOut | output | XLEN | Saved PC |
| ssrOut | output | XLEN | Saved status word |
| sgrOut | output | XLEN | Saved stack register |
| expevtOut | output | CODEW | Last exception code |
| intevtOut | output | VECW | Last interrupt vector |

## Verification
The bench builds the block with its defaults: 32-bit words, 12-bit codes and vectors, and a 4-bit mask field. These are the widths at which the fixed vector offsets, the 0xA0000000 reset target and the status-bit positions all fit. Each class of exception code is driven once in turn, so every vector target and every status-word rewrite is reached. The delay-slot and trap adjustments are checked alone and together. The block-bit paths are covered: escalation, the 0x1E0 bypass, and the sleeping interrupt. Interrupts are tried with and without a controller vector, and inside a delay slot.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // Status-word bit positions decoded by the rest of the core
  localparam int BL_BIT    = 28;
  localparam int RB_BIT    = 29;
  localparam int MD_BIT    = 30;
  localparam int FD_BIT    = 15;
  localparam int IMASK_LSB = 4;

  // Exception codes with special handling
  localparam int CODE_POWER   = 'h000;
  localparam int CODE_MANRST  = 'h020;
  localparam int CODE_MULTI   = 'h140;
  localparam int CODE_TLBRD   = 'h040;
  localparam int CODE_TLBWR   = 'h060;
  localparam int CODE_TRAP    = 'h160;
  localparam int CODE_NOBLOCK = 'h1E0;

  // Vector offsets
  localparam int OFS_GENERAL = 'h100;
  localparam int OFS_TLB     = 'h400;
  localparam int OFS_IRQ     = 'h600;

  typedef enum logic [1:0] {
    VEC_RESET,
    VEC_TLB,
    VEC_GEN,
    VEC_IRQ
  } vecSel_e;

  typedef struct packed {
    logic    doEntry;
    logic    isExc;
    vecSel_e vecSel;
    logic    spcBack;
    logic    spcFwd;
    logic    reqReset;
    logic    clrSleep;
    logic    clrDelay;
  } seqCtl_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int CODEW = 12
) (
  input  logic             take,
  input  logic             excValid,
  input  logic [CODEW-1:0] excCode,
  input  logic             irqReq,
  input  logic             ctrlVecValid,
  input  logic             inDelaySlot,
  input  logic             sleeping,
  input  logic             blocked,
  output seqCtl_t          ctl
);

  logic irqCand;
  logic blockExc;
  logic blockIrq;
  logic isResetCls;
  logic isTlbCls;

  always_comb begin
    irqCand    = irqReq && !excValid && !inDelaySlot;
    blockExc   = blocked && excValid && (excCode != CODEW'(CODE_NOBLOCK));
    blockIrq   = blocked && irqCand && !sleeping;
    isResetCls = (excCode == CODEW'(CODE_POWER)) ||
                 (excCode == CODEW'(CODE_MANRST)) ||
                 (excCode == CODEW'(CODE_MULTI));
    isTlbCls   = (excCode == CODEW'(CODE_TLBRD)) ||
                 (excCode == CODEW'(CODE_TLBWR));
  end

  always_comb begin
    ctl = '0;
    ctl.vecSel = VEC_GEN;
    if (take) begin
      if (blockExc) begin
        ctl.reqReset = 1'b1;
      end else if (!blockIrq) begin
        ctl.clrSleep = 1'b1;
        if (excValid) begin
          ctl.doEntry = 1'b1;
          ctl.isExc   = 1'b1;
          ctl.spcFwd  = (excCode == CODEW'(CODE_TRAP));
          if (isResetCls)    ctl.vecSel = VEC_RESET;
          else if (isTlbCls) ctl.vecSel = VEC_TLB;
          else               ctl.vecSel = VEC_GEN;
        end else if (irqCand && ctrlVecValid) begin
          ctl.doEntry = 1'b1;
          ctl.vecSel  = VEC_IRQ;
        end
        ctl.spcBack  = ctl.doEntry && inDelaySlot;
        ctl.clrDelay = ctl.doEntry && inDelaySlot;
      end
    end
  end

endmodule

// File: rtl/exc_dpath.sv
module exc_dpath
  import exc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CODEW    = 12,
  parameter int          VECW     = 12,
  parameter int          MASKW    = 4,
  parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [XLEN-1:0]  srIn,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [XLEN-1:0]  r15In,
  input  logic [XLEN-1:0]  vbrIn,
  input  logic [CODEW-1:0] excCode,
  input  logic [VECW-1:0]  ctrlVec,
  output logic             done,
  output logic             resetReq,
  output logic             sleepClr,
  output logic             delayClr,
  output logic [XLEN-1:0]  srOut,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  spcOut,
  output logic [XLEN-1:0]  ssrOut,
  output logic [XLEN-1:0]  sgrOut,
  output logic [CODEW-1:0] expevtOut,
  output logic [VECW-1:0]  intevtOut
);

  logic [XLEN-1:0] backAdj;
  logic [XLEN-1:0] fwdAdj;
  logic [XLEN-1:0] spcNext;
  logic [XLEN-1:0] srNext;
  logic [XLEN-1:0] pcNext;

  always_comb begin
    backAdj = ctl.spcBack ? XLEN'(2) : '0;
    fwdAdj  = ctl.spcFwd  ? XLEN'(2) : '0;
    spcNext = pcIn - backAdj + fwdAdj;
  end

  always_comb begin
    srNext = srIn;
    srNext[BL_BIT] = 1'b1;
    srNext[MD_BIT] = 1'b1;
    srNext[RB_BIT] = 1'b1;
    if (ctl.vecSel == VEC_RESET) begin
      srNext[FD_BIT] = 1'b0;
      srNext[IMASK_LSB +: MASKW] = '1;
    end
  end

  always_comb begin
    unique case (ctl.vecSel)
      VEC_RESET: pcNext = RESET_PC;
      VEC_TLB:   pcNext = vbrIn + XLEN'(OFS_TLB);
      VEC_IRQ:   pcNext = vbrIn + XLEN'(OFS_IRQ);
      default:   pcNext = vbrIn + XLEN'(OFS_GENERAL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      resetReq  <= 1'b0;
      sleepClr  <= 1'b0;
      delayClr  <= 1'b0;
      srOut     <= '0;
      pcOut     <= '0;
      spcOut    <= '0;
      ssrOut    <= '0;
      sgrOut    <= '0;
      expevtOut <= '0;
      intevtOut <= '0;
    end else begin
      done     <= ctl.doEntry;
      resetReq <= ctl.reqReset;
      sleepClr <= ctl.clrSleep;
      delayClr <= ctl.clrDelay;
      if (ctl.doEntry) begin
        srOut  <= srNext;
        pcOut  <= pcNext;
        spcOut <= spcNext;
        ssrOut <= srIn;
        sgrOut <= r15In;
        if (ctl.isExc) expevtOut <= excCode;
        else           intevtOut <= ctrlVec;
      end
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CODEW = 12,
  parameter int VECW  = 12,
  parameter int MASKW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             take,
  input  logic             excValid,
  input  logic [CODEW-1:0] excCode,
  input  logic             irqReq,
  input  logic             ctrlVecValid,
  input  logic [VECW-1:0]  ctrlVec,
  output logic [MASKW-1:0] irqLevel,
  input  logic [XLEN-1:0]  srIn,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [XLEN-1:0]  r15In,
  input  logic [XLEN-1:0]  vbrIn,
  input  logic             inDelaySlot,
  input  logic             sleeping,
  output logic             done,
  output logic             resetReq,
  output logic             sleepClr,
  output logic             delayClr,
  output logic [XLEN-1:0]  srOut,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  spcOut,
  output logic [XLEN-1:0]  ssrOut,
  output logic [XLEN-1:0]  sgrOut,
  output logic [CODEW-1:0] expevtOut,
  output logic [VECW-1:0]  intevtOut
);

  seqCtl_t ctl;

  assign irqLevel = srIn[IMASK_LSB +: MASKW];

  exc_ctrl #(.CODEW(CODEW)) ctrl_i (
    .take         (take),
    .excValid     (excValid),
    .excCode      (excCode),
    .irqReq       (irqReq),
    .ctrlVecValid (ctrlVecValid),
    .inDelaySlot  (inDelaySlot),
    .sleeping     (sleeping),
    .blocked      (srIn[BL_BIT]),
    .ctl          (ctl)
  );

  exc_dpath #(
    .XLEN(XLEN), .CODEW(CODEW), .VECW(VECW), .MASKW(MASKW)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .srIn      (srIn),
    .pcIn      (pcIn),
    .r15In     (r15In),
    .vbrIn     (vbrIn),
    .excCode   (excCode),
    .ctrlVec   (ctrlVec),
    .done      (done),
    .resetReq  (resetReq),
    .sleepClr  (sleepClr),
    .delayClr  (delayClr),
    .srOut     (srOut),
    .pcOut     (pcOut),
    .spcOut    (spcOut),
    .ssrOut    (ssrOut),
    .sgrOut    (sgrOut),
    .expevtOut (expevtOut),
    .intevtOut (intevtOut)
  );

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CODEW = 12,
  parameter int VECW  = 12,
  parameter int MASKW = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             take,
  input logic             excValid,
  input logic [CODEW-1:0] excCode,
  input logic             irqReq,
  input logic [XLEN-1:0]  srIn,
  input logic [XLEN-1:0]  r15In,
  input logic [XLEN-1:0]  vbrIn,
  input logic             inDelaySlot,
  input logic             done,
  input logic             resetReq,
  input logic [XLEN-1:0]  srOut,
  input logic [XLEN-1:0]  pcOut,
  input logic [XLEN-1:0]  ssrOut,
  input logic [XLEN-1:0]  sgrOut,
  input logic [VECW-1:0]  intevtOut
);

  assert_priority_R1: assert property (@(posedge clk) disable iff (!rstN)
    (take && excValid) |=> $stable(intevtOut));

  assert_escalate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (take && excValid && srIn[BL_BIT] && excCode != CODEW'(CODE_NOBLOCK))
      |=> (resetReq && !done));

  assert_entry_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (srOut[BL_BIT] && srOut[MD_BIT] && srOut[RB_BIT]));

  assert_save_regs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (take && excValid && !srIn[BL_BIT])
      |=> (ssrOut == $past(srIn) && sgrOut == $past(r15In)));

  assert_tlb_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    (take && excValid && !srIn[BL_BIT] &&
     (excCode == CODEW'(CODE_TLBRD) || excCode == CODEW'(CODE_TLBWR)))
      |=> (pcOut == $past(vbrIn) + XLEN'(OFS_TLB)));

  assert_delay_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    (take && irqReq && !excValid && inDelaySlot) |=> !done);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !take |=> (!done && !resetReq));

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && resetReq));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .XLEN(XLEN), .CODEW(CODEW), .VECW(VECW), .MASKW(MASKW)
) chk_i (.*);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        take = 1'b0;
  logic        excValid = 1'b0;
  logic [11:0] excCode = '0;
  logic        irqReq = 1'b0;
  logic        ctrlVecValid = 1'b0;
  logic [11:0] ctrlVec = '0;
  logic [3:0]  irqLevel;
  logic [31:0] srIn = '0, pcIn = '0, r15In = '0, vbrIn = '0;
  logic        inDelaySlot = 1'b0;
  logic        sleeping = 1'b0;
  logic        done, resetReq, sleepClr, delayClr;
  logic [31:0] srOut, pcOut, spcOut, ssrOut, sgrOut;
  logic [11:0] expevtOut, intevtOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] PC  = 32'h8C00_1000;
  localparam logic [31:0] SP  = 32'h0000_1234;

  always #10 clk = ~clk;

  exc_entry_seq uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    excValid = 0; excCode = 0; irqReq = 0; ctrlVecValid = 0; ctrlVec = 0;
    srIn = 32'h0000_0030; pcIn = PC; r15In = SP; vbrIn = VBR;
    inDelaySlot = 0; sleeping = 0;
  endtask

  task automatic fire();
    take = 1;
    @(negedge clk);
    take = 0;
  endtask

  task automatic exc_go(input logic [11:0] code, input logic [31:0] sr, input logic dly);
    @(negedge clk);
    idle();
    excValid = 1; excCode = code; srIn = sr; inDelaySlot = dly;
    fire();
  endtask

  task automatic t_reset_state();
    chk("R11 done after reset", {31'b0, done}, 0);
    chk("R11 resetReq after reset", {31'b0, resetReq}, 0);
    chk("R11 pcOut after reset", pcOut, 0);
    chk("R11 srOut after reset", srOut, 0);
  endtask

  task automatic t_general();
    exc_go(12'h180, 32'h0000_0030, 0);
    chk("R4 done", {31'b0, done}, 1);
    chk("R4 sleepClr", {31'b0, sleepClr}, 1);
    chk("R4 ssrOut", ssrOut, 32'h0000_0030);
    chk("R4 spcOut", spcOut, PC);
    chk("R4 sgrOut", sgrOut, SP);
    chk("R4 srOut", srOut, 32'h7000_0030);
    chk("R5 no delayClr", {31'b0, delayClr}, 0);
    chk("R7 general pc", pcOut, VBR + 32'h100);
    chk("R7 expevt", {20'b0, expevtOut}, 32'h180);
  endtask

  task automatic t_tlb();
    exc_go(12'h040, 32'h0000_0030, 0);
    chk("R7 tlb read pc", pcOut, VBR + 32'h400);
    exc_go(12'h060, 32'h0000_0030, 0);
    chk("R7 tlb write pc", pcOut, VBR + 32'h400);
    chk("R7 expevt 060", {20'b0, expevtOut}, 32'h060);
  endtask

  task automatic t_reset_class();
    exc_go(12'h020, 32'h0000_8010, 0);
    chk("R6 pc 020", pcOut, 32'hA000_0000);
    chk("R6 sr 020", srOut, 32'h7000_00F0);
    exc_go(12'h140, 32'h0000_8000, 0);
    chk("R6 pc 140", pcOut, 32'hA000_0000);
    chk("R6 sr 140", srOut, 32'h7000_00F0);
    exc_go(12'h000, 32'h0000_8000, 0);
    chk("R6 pc 000", pcOut, 32'hA000_0000);
  endtask

  task automatic t_delay_trap();
    exc_go(12'h180, 32'h0000_0030, 1);
    chk("R5 spc back", spcOut, PC - 2);
    chk("R5 delayClr", {31'b0, delayClr}, 1);
    exc_go(12'h160, 32'h0000_0030, 0);
    chk("R8 trap spc", spcOut, PC + 2);
    chk("R8 trap pc", pcOut, VBR + 32'h100);
    exc_go(12'h160, 32'h0000_0030, 1);
    chk("R8 trap in delay", spcOut, PC);
  endtask

  task automatic t_blocked();
    logic [31:0] prevPc, prevSpc;
    exc_go(12'h040, 32'h0000_0030, 0);
    prevPc = pcOut; prevSpc = spcOut;
    exc_go(12'h180, 32'h1000_0030, 0);
    chk("R2 resetReq", {31'b0, resetReq}, 1);
    chk("R2 no done", {31'b0, done}, 0);
    chk("R2 pc held", pcOut, prevPc);
    chk("R2 spc held", spcOut, prevSpc);
    @(negedge clk);
    chk("R2 resetReq one cycle", {31'b0, resetReq}, 0);
    exc_go(12'h1E0, 32'h1000_0020, 0);
    chk("R2 bypass done", {31'b0, done}, 1);
    chk("R2 bypass pc", pcOut, VBR + 32'h100);
    chk("R2 bypass sr", srOut, 32'h7000_0020);
  endtask

  task automatic t_irq();
    logic [31:0] prevPc;
    logic [11:0] prevExp;
    @(negedge clk);
    idle();
    irqReq = 1; ctrlVecValid = 1; ctrlVec = 12'h3A0; srIn = 32'h0000_0050;
    #1;
    chk("R9 irqLevel", {28'b0, irqLevel}, 5);
    prevExp = expevtOut;
    fire();
    chk("R9 irq done", {31'b0, done}, 1);
    chk("R9 intevt", {20'b0, intevtOut}, 32'h3A0);
    chk("R9 irq pc", pcOut, VBR + 32'h600);
    chk("R9 expevt held", {20'b0, expevtOut}, {20'b0, prevExp});
    prevPc = pcOut;
    @(negedge clk);
    idle();
    irqReq = 1; ctrlVecValid = 0;
    fire();
    chk("R9 no vector no done", {31'b0, done}, 0);
    chk("R9 no vector sleepClr", {31'b0, sleepClr}, 1);
    chk("R9 no vector pc held", pcOut, prevPc);
  endtask

  task automatic t_irq_blocked();
    @(negedge clk);
    idle();
    irqReq = 1; ctrlVecValid = 1; ctrlVec = 12'h400; srIn = 32'h1000_0000;
    fire();
    chk("R3 masked irq done", {31'b0, done}, 0);
    chk("R3 masked irq sleepClr", {31'b0, sleepClr}, 0);
    @(negedge clk);
    idle();
    irqReq = 1; ctrlVecValid = 1; ctrlVec = 12'h420; srIn = 32'h1000_0000; sleeping = 1;
    fire();
    chk("R3 sleeping irq done", {31'b0, done}, 1);
    chk("R3 sleeping irq intevt", {20'b0, intevtOut}, 32'h420);
  endtask

  task automatic t_irq_delay();
    logic [11:0] prevInt;
    prevInt = intevtOut;
    @(negedge clk);
    idle();
    irqReq = 1; ctrlVecValid = 1; ctrlVec = 12'h500; inDelaySlot = 1;
    fire();
    chk("R10 delay irq done", {31'b0, done}, 0);
    chk("R10 intevt held", {20'b0, intevtOut}, {20'b0, prevInt});
  endtask

  task automatic t_priority();
    logic [11:0] prevInt;
    prevInt = intevtOut;
    @(negedge clk);
    idle();
    excValid = 1; excCode = 12'h1A0; irqReq = 1; ctrlVecValid = 1; ctrlVec = 12'h600;
    fire();
    chk("R1 expevt wins", {20'b0, expevtOut}, 32'h1A0);
    chk("R1 intevt held", {20'b0, intevtOut}, {20'b0, prevInt});
    chk("R1 pc general", pcOut, VBR + 32'h100);
  endtask

  task automatic t_no_take();
    logic [31:0] prevPc;
    prevPc = pcOut;
    @(negedge clk);
    idle();
    excValid = 1; excCode = 12'h040; vbrIn = 32'h1111_0000;
    repeat (3) @(negedge clk);
    chk("R11 no take done", {31'b0, done}, 0);
    chk("R11 no take pc held", pcOut, prevPc);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset_state();
    t_general();
    t_tlb();
    t_reset_class();
    t_delay_trap();
    t_blocked();
    t_irq();
    t_irq_blocked();
    t_irq_delay();
    t_priority();
    t_no_take();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule